// File: doc/BRIEF.md
# Camera Byte Stream to RGB565 Pixel Converter

This block sits right behind a camera capture front end. It receives pixel data one byte at a time, with a valid strobe, and produces one 16-bit RGB565 word for each pixel. A format select input chooses how the bytes are read. In luma/chroma mode the bytes form four-byte groups. Each group carries two luma samples and one shared pair of colour-difference samples. The block rebuilds a full luma/blue-difference/red-difference triple for each of the two pixels. It converts each triple to RGB with fixed-point coefficients, then clamps and truncates the result to 5/6/5 bits. In RGB mode the conversion is bypassed and each pair of bytes is simply joined into one word.

A frame-start pulse realigns the byte counter, so the first byte of every frame is taken as the start of a group. The first pixel produced after that pulse carries a frame-start flag, which a downstream memory writer can use to find frame boundaries. The output strobe goes with each converted pixel. The output word always fits a single 16-bit memory location.

Top module: `pixfmt_conv`

## Requirements
- R1: After reset, pix_vld_o and pix_sof_o are low and pix_o is zero until the first pixel is produced.
- R2: With fmt_sel_i = 0 (luma/chroma), accepted bytes are taken cyclically as Y0, Cb, Y1, Cr. Suppose the Cr byte is sampled at rising edge E. Then pixel 0 appears on the outputs after edge E+1 and pixel 1 after edge E+2, on two consecutive cycles. pix_vld_o is low after edge E.
- R3: Both pixels of a group use that group's Cb and Cr. Pixel 0 uses Y0 and pixel 1 uses Y1.
- R4: The conversion uses integer arithmetic with c = Y-16, d = Cb-128 and e = Cr-128, where >>> is an arithmetic (floor) shift. The channels are R = (298c + 409e + 128) >>> 8, G = (298c - 100d - 208e + 128) >>> 8 and B = (298c + 516d + 128) >>> 8.
- R5: Each channel is clamped to 0..255 before packing. R[7:3] goes to pix_o[15:11], G[7:2] to pix_o[10:5], and B[7:3] to pix_o[4:0].
- R6: With fmt_sel_i = 1 (RGB565), the first byte of a pair is pix_o[15:8] and the second is pix_o[7:0], with no conversion. The word appears after edge E+1, where E is the edge that sampled the second byte.
- R7: A cycle with sof_i high resets the byte position, so a byte accepted in that same cycle (or the next accepted byte) is treated as the first of a group. Bytes of an unfinished group are discarded and produce no output.
- R8: pix_sof_o is high only together with pix_vld_o. It is high on the first pixel produced after sof_i and on no later pixel.
- R9: Cycles with byte_vld_i low have no effect on pixel values or grouping. pix_vld_o is high for exactly one cycle per pixel, and pix_o holds its value while pix_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Input byte |
| fmt_sel_i | input | 1 | 0: luma/chroma 4:2:2 bytes, 1: RGB565 byte pairs |
| sof_i | input | 1 | Frame-start pulse, realigns the byte position |
| pix_vld_o | output | 1 | Output pixel strobe |
| pix_o | output | 16 | RGB565 pixel |
| pix_sof_o | output | 1 | First pixel of a frame |

## Verification
A wrong byte position shows up at the ports within one group. Luma and chroma trade places, so a sweep over distinct Y, Cb and Cr values produces wrong colours on the very next pair of pixels. It also shifts the output strobe by one or more cycles relative to the Cr edge. A bad pair hold register or clamp only affects the second pixel of a group, or pixels at extreme values, so the sweep covers the full value range, including 0 and 255. A frame-start flag that is stale, or one that is lost, is visible on the first pixel after each realignment. Dropping a partial group is checked by confirming that no extra pixel appears.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int FRAC_W  = 8;
    localparam int ACC_W   = 20;
    localparam int Y_OFS   = 16;
    localparam int C_OFS   = 128;
    localparam int K_Y     = 298;
    localparam int K_RV    = 409;
    localparam int K_GU    = 100;
    localparam int K_GV    = 208;
    localparam int K_BU    = 516;
    localparam int R_BITS  = 5;
    localparam int G_BITS  = 6;
    localparam int B_BITS  = 5;
    localparam int CHAN_MAX = (1 << BYTE_W) - 1;

    typedef enum logic {
        FMT_YCC = 1'b0,
        FMT_RGB = 1'b1
    } fmt_e;

    typedef struct packed {
        logic              vld;
        logic              sof;
        logic              raw;
        logic [BYTE_W-1:0] y;
        logic [BYTE_W-1:0] cb;
        logic [BYTE_W-1:0] cr;
        logic [WORD_W-1:0] word;
    } unp_out_t;

endpackage

// File: rtl/pixfmt_unpack.sv
module pixfmt_unpack
    import pixfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              mode_i,
    input  logic              sof_i,
    output unp_out_t          out_o
);

    typedef struct packed {
        logic [1:0]        phase;
        logic [BYTE_W-1:0] y0;
        logic [BYTE_W-1:0] cb;
        logic [BYTE_W-1:0] y1;
        logic [BYTE_W-1:0] py1;
        logic [BYTE_W-1:0] pcb;
        logic [BYTE_W-1:0] pcr;
        logic              pend2;
        logic              sofp;
        unp_out_t          out;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] ph;
    fmt_e       mode;

    assign mode = fmt_e'(mode_i);

    always_comb begin
        st_d          = st_q;
        st_d.out.vld  = 1'b0;
        st_d.out.sof  = 1'b0;
        st_d.out.raw  = 1'b0;
        st_d.pend2    = 1'b0;
        ph            = sof_i ? 2'd0 : st_q.phase;

        // second pixel of a completed group, shared chroma
        if (st_q.pend2) begin
            st_d.out.vld = 1'b1;
            st_d.out.y   = st_q.py1;
            st_d.out.cb  = st_q.pcb;
            st_d.out.cr  = st_q.pcr;
        end

        if (sof_i) begin
            st_d.phase = 2'd0;
            st_d.sofp  = 1'b1;
        end

        if (byte_vld_i) begin
            if (mode == FMT_RGB) begin
                if (ph == 2'd0) begin
                    st_d.y0    = byte_i;
                    st_d.phase = 2'd1;
                end else begin
                    st_d.out.vld  = 1'b1;
                    st_d.out.raw  = 1'b1;
                    st_d.out.sof  = st_q.sofp;
                    st_d.out.word = {st_q.y0, byte_i};
                    st_d.phase    = 2'd0;
                    st_d.sofp     = 1'b0;
                end
            end else begin
                unique case (ph)
                    2'd0: begin st_d.y0 = byte_i; st_d.phase = 2'd1; end
                    2'd1: begin st_d.cb = byte_i; st_d.phase = 2'd2; end
                    2'd2: begin st_d.y1 = byte_i; st_d.phase = 2'd3; end
                    default: begin
                        st_d.out.vld = 1'b1;
                        st_d.out.sof = st_q.sofp;
                        st_d.out.y   = st_q.y0;
                        st_d.out.cb  = st_q.cb;
                        st_d.out.cr  = byte_i;
                        st_d.py1     = st_q.y1;
                        st_d.pcb     = st_q.cb;
                        st_d.pcr     = byte_i;
                        st_d.pend2   = 1'b1;
                        st_d.phase   = 2'd0;
                        st_d.sofp    = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    AST_YCC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !sof_i && mode_i == FMT_YCC && st_q.phase == 2'd3)
        |=> (out_o.vld && !out_o.raw) ##1 (out_o.vld && !out_o.raw && !out_o.sof)); // R2

    AST_RGB_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !sof_i && mode_i == FMT_RGB && st_q.phase == 2'd1)
        |=> (out_o.vld && out_o.raw)); // R6

    AST_SOF_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (st_q.phase == ($past(byte_vld_i) ? 2'd1 : 2'd0))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld_i && !st_q.pend2) |=> !out_o.vld); // R9

endmodule

// File: rtl/pixfmt_csc.sv
module pixfmt_csc
    import pixfmt_pkg::*;
(
    input  logic [BYTE_W-1:0] y_i,
    input  logic [BYTE_W-1:0] cb_i,
    input  logic [BYTE_W-1:0] cr_i,
    output logic [WORD_W-1:0] rgb_o
);

    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W - 1));

    logic signed [ACC_W-1:0] ys, us, vs;
    logic signed [ACC_W-1:0] r_acc, g_acc, b_acc;
    logic [BYTE_W-1:0]       r8, g8, b8;

    function automatic logic [BYTE_W-1:0] sat(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] s;
        s = a >>> FRAC_W;
        if (s < 0)
            return '0;
        else if (s > ACC_W'(CHAN_MAX))
            return BYTE_W'(CHAN_MAX);
        else
            return s[BYTE_W-1:0];
    endfunction

    always_comb begin
        ys    = signed'(ACC_W'(y_i))  - signed'(ACC_W'(Y_OFS));
        us    = signed'(ACC_W'(cb_i)) - signed'(ACC_W'(C_OFS));
        vs    = signed'(ACC_W'(cr_i)) - signed'(ACC_W'(C_OFS));
        r_acc = ys * signed'(ACC_W'(K_Y)) + vs * signed'(ACC_W'(K_RV)) + RND;
        g_acc = ys * signed'(ACC_W'(K_Y)) - us * signed'(ACC_W'(K_GU))
              - vs * signed'(ACC_W'(K_GV)) + RND;
        b_acc = ys * signed'(ACC_W'(K_Y)) + us * signed'(ACC_W'(K_BU)) + RND;
        r8    = sat(r_acc);
        g8    = sat(g_acc);
        b8    = sat(b_acc);
        rgb_o = {r8[BYTE_W-1 -: R_BITS], g8[BYTE_W-1 -: G_BITS], b8[BYTE_W-1 -: B_BITS]};
    end

endmodule

// File: rtl/pixfmt_conv.sv
module pixfmt_conv
    import pixfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              fmt_sel_i,
    input  logic              sof_i,
    output logic              pix_vld_o,
    output logic [WORD_W-1:0] pix_o,
    output logic              pix_sof_o
);

    typedef struct packed {
        logic              vld;
        logic              sof;
        logic [WORD_W-1:0] word;
    } pix_t;

    unp_out_t          unp;
    logic [WORD_W-1:0] csc_word;
    pix_t              pix_d, pix_q;

    pixfmt_unpack u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .mode_i     (fmt_sel_i),
        .sof_i      (sof_i),
        .out_o      (unp)
    );

    pixfmt_csc u_csc (
        .y_i   (unp.y),
        .cb_i  (unp.cb),
        .cr_i  (unp.cr),
        .rgb_o (csc_word)
    );

    always_comb begin
        pix_d     = pix_q;
        pix_d.vld = unp.vld;
        pix_d.sof = unp.vld && unp.sof;
        if (unp.vld) begin
            pix_d.word = unp.raw ? unp.word : csc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign pix_vld_o = pix_q.vld;
    assign pix_o     = pix_q.word;
    assign pix_sof_o = pix_q.sof;

    AST_SOF_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof_o |-> pix_vld_o); // R8

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld_o |-> $stable(pix_o)); // R9

endmodule

// File: tb/tb_pixfmt_conv.sv
`timescale 1ns/1ps
module tb_pixfmt_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_d = 8'd0;
    logic        fmt = 1'b0;
    logic        sof = 1'b0;
    logic        pix_vld;
    logic [15:0] pix;
    logic        pix_sof;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_w_q[$];
    bit          exp_s_q[$];
    string       exp_t_q[$];

    always #2.5 clk = ~clk;

    pixfmt_conv dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_d),
        .fmt_sel_i  (fmt),
        .sof_i      (sof),
        .pix_vld_o  (pix_vld),
        .pix_o      (pix),
        .pix_sof_o  (pix_sof)
    );

    function automatic int sat8(input int a);
        int s;
        s = a >>> 8;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    function automatic logic [15:0] ref_pix(input int y, input int cb, input int cr);
        int c, d, e, r, g, b;
        c = y - 16; d = cb - 128; e = cr - 128;
        r = sat8(298 * c + 409 * e + 128);
        g = sat8(298 * c - 100 * d - 208 * e + 128);
        b = sat8(298 * c + 516 * d + 128);
        return {r[7:3], g[7:2], b[7:3]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input bit s, input bit m);
        @(negedge clk);
        byte_vld = 1'b1; byte_d = b; sof = s; fmt = m;
    endtask

    task automatic idle();
        @(negedge clk);
        byte_vld = 1'b0; sof = 1'b0;
    endtask

    task automatic push(input logic [15:0] w, input bit s, input string t);
        exp_w_q.push_back(w); exp_s_q.push_back(s); exp_t_q.push_back(t);
    endtask

    // one luma/chroma group; expectations pushed for R3/R4/R5
    task automatic ycc_group(input int y0, input int cb, input int y1, input int cr,
                             input bit s, input int gap, input string t);
        push(ref_pix(y0, cb, cr), s, t);
        push(ref_pix(y1, cb, cr), 1'b0, t);
        put(8'(y0), s, 1'b0);
        for (int k = 0; k < gap; k++) idle();
        put(8'(cb), 1'b0, 1'b0);
        put(8'(y1), 1'b0, 1'b0);
        for (int k = 0; k < gap; k++) idle();
        put(8'(cr), 1'b0, 1'b0);
    endtask

    task automatic rgb_pair(input logic [15:0] w, input bit s, input int gap, input string t);
        push(w, s, t);
        put(w[15:8], s, 1'b1);
        for (int k = 0; k < gap; k++) idle();
        put(w[7:0], 1'b0, 1'b1);
    endtask

    // scoreboard: output side
    always @(negedge clk) begin
        if (rst_n && !done && pix_vld) begin
            if (exp_w_q.size() == 0) begin
                check(1'b0, "R7/R9 unexpected pixel", int'(pix), 0);
            end else begin
                logic [15:0] w;
                bit s;
                string t;
                w = exp_w_q.pop_front(); s = exp_s_q.pop_front(); t = exp_t_q.pop_front();
                check(pix == w, {t, " pixel"}, int'(pix), int'(w));
                check(pix_sof == s, "R8 frame flag", int'(pix_sof), int'(s));
            end
        end else if (rst_n && !done && !pix_vld) begin
            check(pix_sof == 1'b0, "R8 flag without strobe", int'(pix_sof), 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pix_vld == 1'b0, "R1 vld in reset", int'(pix_vld), 0);
        check(pix_sof == 1'b0, "R1 sof in reset", int'(pix_sof), 0);
        check(pix == 16'd0, "R1 word in reset", int'(pix), 0);
        @(negedge clk); rst_n = 1'b1;
        idle();
        check(pix_vld == 1'b0 && pix == 16'd0, "R1 after release", int'(pix), 0);

        // R2: timing of a luma/chroma group, first flagged (R8)
        ycc_group(81, 90, 145, 240, 1'b1, 0, "R2");
        idle(); check(pix_vld == 1'b0, "R2 no pixel after Cr edge", int'(pix_vld), 0);
        idle(); check(pix_vld == 1'b1, "R2 pixel0 after E+1", int'(pix_vld), 1);
        idle(); check(pix_vld == 1'b1, "R2 pixel1 after E+2", int'(pix_vld), 1);
        idle(); check(pix_vld == 1'b0, "R2 strobe ends", int'(pix_vld), 0);
        repeat (2) idle();

        // R3/R4/R5/R9: sweep over Y, Cb, Cr, with idle gaps on some groups
        for (int yi = 0; yi < 16; yi++) begin
            for (int bi = 0; bi < 16; bi++) begin
                for (int ri = 0; ri < 16; ri++) begin
                    ycc_group(yi * 17, bi * 17, 255 - yi * 17, ri * 17, 1'b0,
                              ((yi + bi + ri) % 5 == 0) ? 1 : 0, "R3/R4/R5");
                end
            end
        end
        repeat (4) idle();

        // R6: RGB565 timing, first flagged
        rgb_pair(16'hA53C, 1'b1, 0, "R6");
        idle(); check(pix_vld == 1'b0, "R6 no pixel after low edge", int'(pix_vld), 0);
        idle(); check(pix_vld == 1'b1 && pix == 16'hA53C, "R6 word after E+1", int'(pix), 16'hA53C);
        idle(); check(pix_vld == 1'b0, "R6 single strobe", int'(pix_vld), 0);

        // R6/R9: RGB sweep, gaps on some pairs
        for (int i = 0; i < 512; i++) begin
            rgb_pair(16'(i * 131 + 7), 1'b0, (i % 4 == 1) ? 2 : 0, "R6");
        end
        repeat (3) idle();

        // R7: partial RGB pair dropped, realigned by frame start
        put(8'h12, 1'b1, 1'b1);
        idle();
        rgb_pair(16'h3456, 1'b1, 0, "R7 rgb realign");
        repeat (3) idle();

        // R7: partial luma/chroma group dropped
        put(8'd50, 1'b1, 1'b0);
        put(8'd60, 1'b0, 1'b0);
        put(8'd70, 1'b0, 1'b0);
        ycc_group(200, 30, 20, 220, 1'b1, 0, "R7 ycc realign");
        // R8: next group in frame carries no flag
        ycc_group(128, 128, 16, 128, 1'b0, 0, "R8 second group");
        repeat (3) idle();

        // R7/R8: frame start without a byte, next byte begins the group
        @(negedge clk); byte_vld = 1'b0; sof = 1'b1; fmt = 1'b0;
        ycc_group(235, 16, 235, 16, 1'b0, 0, "R7 sof alone");
        exp_s_q[exp_s_q.size() - 2] = 1'b1;
        repeat (4) idle();

        check(exp_w_q.size() == 0, "R2 all expected pixels seen", exp_w_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule